// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, day of month, weekday, month and a two-digit year (2000 to 2099). A free-running oscillator enable input is divided down by a parameterised prescaler into a one-second advance. Software reaches the block through a simple byte register port with separate write and read addresses. The time fields live at addresses 0x03 to 0x09, and a control byte lives at address 0x00.

The control byte chooses 24-hour or 12-hour presentation of the hours field, freezes counting, and requests a software reset. Hours are held internally in 24-hour form and converted at the port, so changing the mode never corrupts the stored time. Bit 7 of the seconds byte is an integrity flag. It is raised by an oscillator-failure input and by reset. It stays raised while time keeps running, until software writes the seconds byte.

Top module: `rtc_bcd_clock`

## Requirements
- R1: After reset, reads return seconds 0x80 (integrity flag set, 00 s), minutes 0x00, hours 0x00, date 0x01, weekday 0x00, month 0x01, year 0x00 and control 0x00.
- R2: Each one-second advance increments seconds; 59 s wraps to 00 and carries into minutes; 59 min wraps and carries into hours; hour 23 wraps to 00 and advances the date and the weekday (weekday counts 0 to 6 and then wraps to 0).
- R3: The date wraps to 01 after the last day of the month (30 for months 04, 06, 09, 11; 31 for the others except 02) and advances the month; month 12 wraps to 01 and advances the year; year 99 wraps to 00.
- R4: February has 29 days when the year is divisible by 4 (00 included) and 28 days otherwise.
- R5: With control bit 3 set, hours are read and written as BCD 1 to 12 in bits 4:0 with PM in bit 5; 11 AM advances to 12 PM (0x32), 11 PM advances to 12 AM (0x12) and moves the date; with bit 3 clear, hours are BCD 00 to 23.
- R6: With control bit 5 set, the time does not advance; after it is cleared, counting resumes.
- R7: A pulse on osc_fail sets bit 7 of seconds; the flag survives time advances and writes to other registers, time keeps counting, and a seconds write loads bit 7 from the written data.
- R8: When osc_fail and a seconds write fall in the same cycle, the flag ends set and the written seconds value is kept.
- R9: A write to address 0x00 or 0x03 to 0x09 takes effect at once and restarts the prescaler, so the next advance comes after DIV further oscillator enables; an advance pending in the same cycle as such a write is dropped.
- R10: Writing control with bit 4 set restores every time field and the control byte to the R1 values; bit 4 always reads 0.
- R11: rd_data shows the register at rd_addr one clock after the address is presented; addresses other than 0x00 and 0x03 to 0x09 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One pulse per oscillator period; DIV pulses make one second |
| osc_fail | input | 1 | Oscillator failure indication, sets the integrity flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | 8 | Registered read data |

## Verification
The interesting collision is a register write landing in the same cycle as the one-second advance. The bench lines the oscillator enables up so the advance is pending, then writes seconds in exactly that cycle. It expects the written value with no increment on top, and no further increment until DIV fresh enables have passed. A second collision, an oscillator failure coinciding with a seconds write, is provoked the same way and judged by the flag reading back set alongside the written seconds.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned REG_CTRL  = 0;
  localparam int unsigned REG_SEC   = 3;
  localparam int unsigned REG_MIN   = 4;
  localparam int unsigned REG_HOUR  = 5;
  localparam int unsigned REG_DATE  = 6;
  localparam int unsigned REG_WDAY  = 7;
  localparam int unsigned REG_MONTH = 8;
  localparam int unsigned REG_YEAR  = 9;

  localparam int CTL_H12  = 3;
  localparam int CTL_SRST = 4;
  localparam int CTL_HALT = 5;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;   // always 24-hour BCD
    logic [5:0] date;
    logic [2:0] wday;
    logic [4:0] month;
    logic [7:0] year;
  } rtc_time_t;

  localparam rtc_time_t TIME_INIT = '{sec: 7'h00, min: 7'h00, hour: 6'h00,
                                      date: 6'h01, wday: 3'd0, month: 5'h01,
                                      year: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] bin_to_bcd(input logic [6:0] b);
    logic [6:0] t;
    logic [6:0] u;
    t = b / 7'd10;
    u = b - t * 7'd10;
    return {t[3:0], u[3:0]};
  endfunction

  function automatic logic [5:0] month_len(input logic [4:0] m, input logic [7:0] y);
    logic [6:0] yb;
    yb = bcd_to_bin(y);
    case (m)
      5'h02:                      return (yb[1:0] == 2'b00) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  function automatic logic [7:0] hour_to_12(input logic [5:0] h24);
    logic [6:0] b;
    logic       pm;
    logic [7:0] d;
    b  = bcd_to_bin({2'b00, h24});
    pm = (b >= 7'd12);
    if (pm) b = b - 7'd12;
    if (b == 7'd0) b = 7'd12;
    d = bin_to_bcd(b);
    return {2'b00, pm, d[4:0]};
  endfunction

  function automatic logic [5:0] hour_from_12(input logic [7:0] v);
    logic [6:0] b;
    logic [7:0] d;
    b = bcd_to_bin({3'b000, v[4:0]});
    if (b == 7'd12) b = 7'd0;
    if (v[5]) b = b + 7'd12;
    d = bin_to_bcd(b);
    return d[5:0];
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_en,
  input  logic restart,
  input  logic hold,
  output logic sec_tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart || hold) begin
      cnt      <= '0;
      sec_tick <= 1'b0;
    end else if (osc_en) begin
      sec_tick <= (cnt == LAST);
      cnt      <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end else begin
      sec_tick <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sec_tick,
  input  logic          osc_fail,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output rtc_time_t     cur,
  output logic          flag,
  output logic          mode12,
  output logic          halt
);
  localparam logic [AW-1:0] A_CTRL  = AW'(REG_CTRL);
  localparam logic [AW-1:0] A_SEC   = AW'(REG_SEC);
  localparam logic [AW-1:0] A_MIN   = AW'(REG_MIN);
  localparam logic [AW-1:0] A_HOUR  = AW'(REG_HOUR);
  localparam logic [AW-1:0] A_DATE  = AW'(REG_DATE);
  localparam logic [AW-1:0] A_WDAY  = AW'(REG_WDAY);
  localparam logic [AW-1:0] A_MONTH = AW'(REG_MONTH);
  localparam logic [AW-1:0] A_YEAR  = AW'(REG_YEAR);

  rtc_time_t  nxt;
  logic [5:0] last_day;
  logic       soft_rst;
  logic       sec_wr;
  logic [7:0] t8;

  assign soft_rst = wr_en && (wr_addr == A_CTRL) && wr_data[CTL_SRST];
  assign sec_wr   = wr_en && (wr_addr == A_SEC);
  assign last_day = month_len(cur.month, cur.year);

  // one-second advance with the full carry chain
  always_comb begin
    nxt = cur;
    t8  = '0;
    if (cur.sec == 7'h59) begin
      nxt.sec = '0;
      if (cur.min == 7'h59) begin
        nxt.min = '0;
        if (cur.hour == 6'h23) begin
          nxt.hour = '0;
          nxt.wday = (cur.wday >= 3'd6) ? 3'd0 : cur.wday + 3'd1;
          if (cur.date == last_day) begin
            nxt.date = 6'h01;
            if (cur.month == 5'h12) begin
              nxt.month = 5'h01;
              nxt.year  = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
            end else begin
              t8        = bcd_inc({3'b000, cur.month});
              nxt.month = t8[4:0];
            end
          end else begin
            t8       = bcd_inc({2'b00, cur.date});
            nxt.date = t8[5:0];
          end
        end else begin
          t8       = bcd_inc({2'b00, cur.hour});
          nxt.hour = t8[5:0];
        end
      end else begin
        t8      = bcd_inc({1'b0, cur.min});
        nxt.min = t8[6:0];
      end
    end else begin
      t8      = bcd_inc({1'b0, cur.sec});
      nxt.sec = t8[6:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      cur    <= TIME_INIT;
      mode12 <= 1'b0;
      halt   <= 1'b0;
    end else if (wr_en) begin
      if      (wr_addr == A_CTRL)  begin mode12 <= wr_data[CTL_H12]; halt <= wr_data[CTL_HALT]; end
      else if (wr_addr == A_SEC)   cur.sec   <= wr_data[6:0];
      else if (wr_addr == A_MIN)   cur.min   <= wr_data[6:0];
      else if (wr_addr == A_HOUR)  cur.hour  <= mode12 ? hour_from_12(wr_data) : wr_data[5:0];
      else if (wr_addr == A_DATE)  cur.date  <= wr_data[5:0];
      else if (wr_addr == A_WDAY)  cur.wday  <= wr_data[2:0];
      else if (wr_addr == A_MONTH) cur.month <= wr_data[4:0];
      else if (wr_addr == A_YEAR)  cur.year  <= wr_data;
      else if (sec_tick)           cur       <= nxt;
    end else if (sec_tick) begin
      cur <= nxt;
    end
  end

  // integrity flag: failure beats everything, then reset, then a seconds write
  always_ff @(posedge clk) begin
    if (rst || osc_fail || soft_rst) flag <= 1'b1;
    else if (sec_wr)                 flag <= wr_data[7];
  end
endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
  import rtc_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr,
  input  rtc_time_t     cur,
  input  logic          flag,
  input  logic          mode12,
  input  logic          halt,
  output logic [7:0]    rd_data
);
  logic [7:0] sel;

  always_comb begin
    sel = 8'h00;
    case (rd_addr)
      AW'(REG_CTRL):  begin sel[CTL_H12] = mode12; sel[CTL_HALT] = halt; end
      AW'(REG_SEC):   sel = {flag, cur.sec};
      AW'(REG_MIN):   sel = {1'b0, cur.min};
      AW'(REG_HOUR):  sel = mode12 ? hour_to_12(cur.hour) : {2'b00, cur.hour};
      AW'(REG_DATE):  sel = {2'b00, cur.date};
      AW'(REG_WDAY):  sel = {5'b00000, cur.wday};
      AW'(REG_MONTH): sel = {3'b000, cur.month};
      AW'(REG_YEAR):  sel = cur.year;
      default:        sel = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'h00;
    else     rd_data <= sel;
  end
endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
  import rtc_pkg::*;
#(
  parameter int DIV = 32768,
  parameter int AW  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          osc_en,
  input  logic          osc_fail,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  rtc_time_t  cur;
  logic       sec_tick;
  logic       flag_w;
  logic       mode12_w;
  logic       halt_w;
  logic       restart;
  logic [6:0] sec_w;

  assign restart = wr_en && ((wr_addr == AW'(REG_CTRL)) ||
                   ((wr_addr >= AW'(REG_SEC)) && (wr_addr <= AW'(REG_YEAR))));
  assign sec_w   = cur.sec;

  rtc_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .osc_en(osc_en), .restart(restart),
    .hold(halt_w), .sec_tick(sec_tick)
  );

  rtc_calendar #(.AW(AW)) u_cal (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .osc_fail(osc_fail),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cur(cur), .flag(flag_w), .mode12(mode12_w), .halt(halt_w)
  );

  rtc_read_mux #(.AW(AW)) u_rd (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .cur(cur), .flag(flag_w),
    .mode12(mode12_w), .halt(halt_w), .rd_data(rd_data)
  );
endmodule

// File: rtl/rtc_bcd_clock_chk.sv
module rtc_bcd_clock_chk #(
  parameter int DIV = 32768,
  parameter int AW  = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          osc_fail,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          restart,
  input logic          sec_tick,
  input logic          halt,
  input logic          flag,
  input logic [6:0]    sec
);
  localparam logic [AW-1:0] A_SEC = AW'(3);

  AST_FAIL_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    osc_fail |=> flag); // R7
  AST_FAIL_BEATS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (osc_fail && wr_en && wr_addr == A_SEC) |=> flag); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !(wr_en && wr_addr == A_SEC)) |=> flag); // R7
  AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    halt |-> !sec_tick); // R6
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!sec_tick && !wr_en) |=> $stable(sec)); // R2
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !wr_en && sec == 7'h59) |=> (sec == 7'h00)); // R2

  if (DIV > 1) begin : g_quiet
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
      restart |=> !sec_tick); // R9
  end
endmodule

bind rtc_bcd_clock rtc_bcd_clock_chk #(.DIV(DIV), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .osc_fail(osc_fail), .wr_en(wr_en), .wr_addr(wr_addr),
  .restart(restart), .sec_tick(sec_tick), .halt(halt_w), .flag(flag_w), .sec(sec_w)
);

// File: tb/rtc_bcd_clock_tb.sv
`timescale 1ns/1ps
module rtc_bcd_clock_tb;
  localparam int DIV = 4;
  localparam int AW  = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          osc_en = 1'b0;
  logic          osc_fail = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_bcd_clock #(.DIV(DIV), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .osc_en(osc_en), .osc_fail(osc_fail),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got 0x%02h expected 0x%02h", req, what, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk); rd_addr = AW'(a);
    @(negedge clk); v = rd_data;
  endtask

  task automatic expect_reg(input string req, input int a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, $sformatf("addr 0x%02h", a), v, exp);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); osc_en = 1'b1; end
    @(negedge clk); osc_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic advance(input int secs);
    pulses(secs * DIV);
  endtask

  task automatic set_time(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                          input logic [7:0] wd, input logic [7:0] h, input logic [7:0] mi,
                          input logic [7:0] s);
    wr(9, y); wr(8, mo); wr(6, d); wr(7, wd); wr(5, h); wr(4, mi); wr(3, s);
  endtask

  task automatic t_reset;
    expect_reg("R1", 3, 8'h80); expect_reg("R1", 4, 8'h00); expect_reg("R1", 5, 8'h00);
    expect_reg("R1", 6, 8'h01); expect_reg("R1", 7, 8'h00); expect_reg("R1", 8, 8'h01);
    expect_reg("R1", 9, 8'h00); expect_reg("R1", 0, 8'h00);
    expect_reg("R11", 1, 8'h00); expect_reg("R11", 10, 8'h00);
  endtask

  task automatic t_rollover;
    set_time(8'h99, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h58);
    advance(1);
    expect_reg("R2", 3, 8'h59);
    advance(1);
    expect_reg("R2", 3, 8'h00); expect_reg("R2", 4, 8'h00); expect_reg("R2", 5, 8'h00);
    expect_reg("R2", 7, 8'h00); expect_reg("R3", 6, 8'h01); expect_reg("R3", 8, 8'h01);
    expect_reg("R3", 9, 8'h00);
  endtask

  task automatic t_months;
    set_time(8'h23, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    advance(1);
    expect_reg("R3", 6, 8'h01); expect_reg("R3", 8, 8'h05); expect_reg("R2", 7, 8'h03);
    set_time(8'h23, 8'h05, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    advance(1);
    expect_reg("R3", 6, 8'h31); expect_reg("R3", 8, 8'h05);
  endtask

  task automatic t_leap;
    set_time(8'h24, 8'h02, 8'h28, 8'h00, 8'h23, 8'h59, 8'h59);
    advance(1);
    expect_reg("R4", 6, 8'h29); expect_reg("R4", 8, 8'h02);
    wr(5, 8'h23); wr(4, 8'h59); wr(3, 8'h59);
    advance(1);
    expect_reg("R4", 6, 8'h01); expect_reg("R4", 8, 8'h03);
    set_time(8'h23, 8'h02, 8'h28, 8'h00, 8'h23, 8'h59, 8'h59);
    advance(1);
    expect_reg("R4", 6, 8'h01); expect_reg("R4", 8, 8'h03);
    set_time(8'h00, 8'h02, 8'h28, 8'h00, 8'h23, 8'h59, 8'h59);
    advance(1);
    expect_reg("R4", 6, 8'h29);
  endtask

  task automatic t_12h;
    set_time(8'h23, 8'h06, 8'h10, 8'h01, 8'h00, 8'h00, 8'h00);
    wr(0, 8'h08);
    expect_reg("R5", 0, 8'h08);
    wr(5, 8'h11); wr(4, 8'h59); wr(3, 8'h59);
    advance(1);
    expect_reg("R5", 5, 8'h32);
    wr(0, 8'h00);
    expect_reg("R5", 5, 8'h12);
    wr(0, 8'h08);
    wr(5, 8'h31); wr(4, 8'h59); wr(3, 8'h59);
    advance(1);
    expect_reg("R5", 5, 8'h12); expect_reg("R5", 6, 8'h11);
    wr(0, 8'h00);
    expect_reg("R5", 5, 8'h00);
  endtask

  task automatic t_halt;
    wr(0, 8'h20);
    wr(3, 8'h05);
    advance(3);
    expect_reg("R6", 3, 8'h05);
    wr(0, 8'h00);
    advance(1);
    expect_reg("R6", 3, 8'h06);
  endtask

  task automatic t_flag;
    wr(3, 8'h10);
    @(negedge clk); osc_fail = 1'b1;
    @(negedge clk); osc_fail = 1'b0;
    expect_reg("R7", 3, 8'h90);
    advance(1);
    expect_reg("R7", 3, 8'h91);
    wr(4, 8'h07);
    expect_reg("R7", 3, 8'h91);
    wr(3, 8'h20);
    expect_reg("R7", 3, 8'h20);
  endtask

  task automatic t_fail_with_write;
    @(negedge clk); osc_fail = 1'b1; wr_en = 1'b1; wr_addr = AW'(3); wr_data = 8'h30;
    @(negedge clk); osc_fail = 1'b0; wr_en = 1'b0;
    expect_reg("R8", 3, 8'hB0);
  endtask

  task automatic t_tick_with_write;
    wr(3, 8'h40);
    for (int i = 0; i < DIV; i++) begin @(negedge clk); osc_en = 1'b1; end
    @(negedge clk); osc_en = 1'b0; wr_en = 1'b1; wr_addr = AW'(3); wr_data = 8'h10;
    @(negedge clk); wr_en = 1'b0;
    expect_reg("R9", 3, 8'h10);
    pulses(DIV - 1);
    expect_reg("R9", 3, 8'h10);
    pulses(1);
    expect_reg("R9", 3, 8'h11);
  endtask

  task automatic t_soft_reset;
    set_time(8'h42, 8'h07, 8'h15, 8'h03, 8'h12, 8'h34, 8'h56);
    wr(0, 8'h28);
    wr(0, 8'h10);
    expect_reg("R10", 0, 8'h00); expect_reg("R10", 3, 8'h80); expect_reg("R10", 4, 8'h00);
    expect_reg("R10", 5, 8'h00); expect_reg("R10", 6, 8'h01); expect_reg("R10", 7, 8'h00);
    expect_reg("R10", 8, 8'h01); expect_reg("R10", 9, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_rollover();
    t_months();
    t_leap();
    t_12h();
    t_halt();
    t_flag();
    t_fail_with_write();
    t_tick_with_write();
    t_soft_reset();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule